// File: doc/BRIEF.md
# I2C Target Address Matcher

This block decides whether a local I2C target is being addressed. It looks only at the first byte received after a START or a repeated START. Bits 7..1 of that byte are the 7-bit calling address and bit 0 is the R/W bit, where 1 means a read. The block compares the calling address against several match sources. Each source is enabled on its own:

- a primary address;
- a range-limit register, which also matches on exact equality whenever it is nonzero;
- a second address;
- the general call address;
- the SMBus alert response address;
- an inclusive window between the primary address and the range-limit register.

One clock after the address byte is accepted, the block updates three outputs: the addressed flag, the captured direction and a code naming the source that won. On a match it also raises a one-cycle ACK request and a transfer-complete flag. A surrounding bit engine uses these to drive the ACK and pick the transmit or receive path before the ACK slot. Any write to the control register clears the addressed flag.

Top module: `tgt_addr_match`

## Requirements
- R1: After reset, addressed, readDir, matchKind, ackReq and xferDone are all 0.
- R2: A calling address (rxByte[7:1]) equal to primAddr is a match with matchKind 1.
- R3: A calling address equal to rangeAddr is a match with matchKind 2, but only when rangeAddr is nonzero. It does not depend on rangeEn.
- R4: With secEn set, a calling address equal to secAddr is a match with matchKind 3.
- R5: With gcEn set, calling address 0 with R/W (rxByte[0]) equal to 0 is a match with matchKind 4. Address 0 with R/W 1 is not a general call.
- R6: With alertEn set, calling address 7'h0C is a match with matchKind 5.
- R7: With rangeEn set, a calling address a with primAddr <= a <= rangeAddr is a match with matchKind 6. If primAddr > rangeAddr the window is empty.
- R8: When several sources match, the smallest matchKind code wins.
- R9: The address byte is accepted on the clock edge where byteValid is high. From the next cycle, addressed equals the match result, matchKind equals the winning code (0 for no match), and readDir equals the R/W bit on a match and 0 otherwise.
- R10: On a match, ackReq is high for exactly the one cycle in which addressed first shows the result. xferDone goes to 1 at the same time and returns to 0 on the edge where startSeen is sampled.
- R11: Only the first byteValid after a startSeen is evaluated. Later bytes leave every output unchanged and raise no ackReq. A byte that arrives in the same cycle as startSeen is ignored.
- R12: ctrlWrite clears addressed and leaves matchKind and readDir alone. If an accepted address byte arrives in the same cycle, the byte's result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startSeen | input | 1 | START or repeated START detected; arms evaluation of the next byte |
| byteValid | input | 1 | rxByte holds a completed received byte |
| rxByte | input | 8 | Received byte: calling address in [7:1], R/W in [0] |
| primAddr | input | 7 | Primary address; lower bound of the window |
| rangeAddr | input | 7 | Range-limit address; upper bound of the window |
| secAddr | input | 7 | Second address |
| gcEn | input | 1 | Enable the general call match |
| secEn | input | 1 | Enable the second address match |
| alertEn | input | 1 | Enable the alert response match |
| rangeEn | input | 1 | Enable the window match |
| ctrlWrite | input | 1 | Control-register write strobe |
| addressed | output | 1 | Target has been addressed |
| readDir | output | 1 | Captured R/W bit (1 = master reads) |
| matchKind | output | 3 | Winning source: 0 none, 1 primary, 2 range register, 3 second, 4 general call, 5 alert, 6 window |
| ackReq | output | 1 | One-cycle ACK request on a match |
| xferDone | output | 1 | Transfer-complete flag |

## Verification
Every 7-bit calling address is sent with both R/W values under four register setups:

- Primary only, with every enable off. This separates the primary match from everything else and shows that a zero range register never matches.
- Everything on, with overlapping sources. The second address, the primary and the range register all sit inside the window, so the priority order between them becomes visible.
- An inverted, empty window, with the second address at zero and gcEn off. This separates the second-address match from the general call at address 0.
- A window reaching the top address, with the general call enabled. This checks the inclusive upper edge and the R/W condition on the general call.

Separate sequences cover bytes that come after the first one, a byte that coincides with startSeen, and control writes made alone and alongside a capture.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE      = 3'd0,
    KIND_PRIMARY   = 3'd1,
    KIND_RANGE_REG = 3'd2,
    KIND_SECOND    = 3'd3,
    KIND_GENERAL   = 3'd4,
    KIND_ALERT     = 3'd5,
    KIND_WINDOW    = 3'd6
  } match_kind_e;

  localparam int NUM_SRC = 6;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clearAddr;
  } ctrl_stb_t;
endpackage

// File: rtl/tam_datapath.sv
module tam_datapath
  import tam_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] GC_ADDR = '0,
  parameter logic [ADDR_W-1:0] ALERT_ADDR = 7'h0C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W:0]     rxByte,
  input  logic [ADDR_W-1:0]   primAddr,
  input  logic [ADDR_W-1:0]   rangeAddr,
  input  logic [ADDR_W-1:0]   secAddr,
  input  logic                gcEn,
  input  logic                secEn,
  input  logic                alertEn,
  input  logic                rangeEn,
  input  ctrl_stb_t           stb,
  output logic                hit,
  output logic                addressed,
  output logic                readDir,
  output logic [KIND_W-1:0]   matchKind
);
  logic [ADDR_W-1:0] callAddr;
  logic              rwBit;
  logic [NUM_SRC:1]  srcHit;
  logic [KIND_W-1:0] kindCode;

  assign callAddr = rxByte[ADDR_W:1];
  assign rwBit    = rxByte[0];

  always_comb begin
    srcHit = '0;
    srcHit[int'(KIND_PRIMARY)]   = (callAddr == primAddr);
    srcHit[int'(KIND_RANGE_REG)] = (rangeAddr != '0) && (callAddr == rangeAddr);
    srcHit[int'(KIND_SECOND)]    = secEn && (callAddr == secAddr);
    srcHit[int'(KIND_GENERAL)]   = gcEn && (callAddr == GC_ADDR) && !rwBit;
    srcHit[int'(KIND_ALERT)]     = alertEn && (callAddr == ALERT_ADDR);
    srcHit[int'(KIND_WINDOW)]    = rangeEn && (callAddr >= primAddr) && (callAddr <= rangeAddr);
  end

  // Lowest code wins: scan from the top down so the last assignment is the smallest
  always_comb begin
    kindCode = KIND_NONE;
    for (int k = NUM_SRC; k >= 1; k--) begin
      if (srcHit[k]) kindCode = KIND_W'(k);
    end
  end

  assign hit = |srcHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addressed <= 1'b0;
      readDir   <= 1'b0;
      matchKind <= KIND_NONE;
    end else if (stb.capture) begin
      addressed <= hit;
      readDir   <= hit & rwBit;
      matchKind <= kindCode;
    end else if (stb.clearAddr) begin
      addressed <= 1'b0;
    end
  end
endmodule

// File: rtl/tam_ctrl.sv
module tam_ctrl
  import tam_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      startSeen,
  input  logic      byteValid,
  input  logic      ctrlWrite,
  input  logic      hit,
  output ctrl_stb_t stb,
  output logic      ackReq,
  output logic      xferDone
);
  logic armed;
  logic takeByte;

  assign takeByte      = byteValid && armed && !startSeen;
  assign stb.capture   = takeByte;
  assign stb.clearAddr = ctrlWrite;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      ackReq   <= 1'b0;
      xferDone <= 1'b0;
    end else begin
      ackReq <= takeByte && hit;
      if (startSeen) begin
        armed    <= 1'b1;
        xferDone <= 1'b0;
      end else begin
        if (takeByte) armed <= 1'b0;
        if (takeByte && hit) xferDone <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tgt_addr_match.sv
module tgt_addr_match
  import tam_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] GC_ADDR = '0,
  parameter logic [ADDR_W-1:0] ALERT_ADDR = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startSeen,
  input  logic              byteValid,
  input  logic [ADDR_W:0]   rxByte,
  input  logic [ADDR_W-1:0] primAddr,
  input  logic [ADDR_W-1:0] rangeAddr,
  input  logic [ADDR_W-1:0] secAddr,
  input  logic              gcEn,
  input  logic              secEn,
  input  logic              alertEn,
  input  logic              rangeEn,
  input  logic              ctrlWrite,
  output logic              addressed,
  output logic              readDir,
  output logic [KIND_W-1:0] matchKind,
  output logic              ackReq,
  output logic              xferDone
);
  ctrl_stb_t stb;
  logic      hit;

  tam_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .startSeen(startSeen), .byteValid(byteValid),
    .ctrlWrite(ctrlWrite), .hit(hit), .stb(stb), .ackReq(ackReq), .xferDone(xferDone)
  );

  tam_datapath #(.ADDR_W(ADDR_W), .GC_ADDR(GC_ADDR), .ALERT_ADDR(ALERT_ADDR)) u_dp (
    .clk(clk), .rst_n(rst_n), .rxByte(rxByte), .primAddr(primAddr),
    .rangeAddr(rangeAddr), .secAddr(secAddr), .gcEn(gcEn), .secEn(secEn),
    .alertEn(alertEn), .rangeEn(rangeEn), .stb(stb), .hit(hit),
    .addressed(addressed), .readDir(readDir), .matchKind(matchKind)
  );
endmodule

// File: rtl/tam_checker.sv
module tam_checker
  import tam_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              byteValid,
  input logic              ctrlWrite,
  input logic              addressed,
  input logic              readDir,
  input logic [KIND_W-1:0] matchKind,
  input logic              ackReq,
  input logic              xferDone
);
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ackReq |=> !ackReq); // R10
  AST_ACK_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ackReq |-> (addressed && xferDone)); // R10
  AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !byteValid |=> !ackReq); // R11
  AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWrite && !byteValid) |=> !addressed); // R12
  AST_ADDR_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    addressed |-> (matchKind != KIND_NONE)); // R9
  AST_GC_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ackReq && matchKind == KIND_GENERAL) |-> !readDir); // R5
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    matchKind <= KIND_WINDOW); // R8
endmodule

bind tgt_addr_match tam_checker u_chk (
  .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .ctrlWrite(ctrlWrite),
  .addressed(addressed), .readDir(readDir), .matchKind(matchKind),
  .ackReq(ackReq), .xferDone(xferDone)
);

// File: tb/tb_tgt_addr_match.sv
module tb_tgt_addr_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startSeen = 1'b0, byteValid = 1'b0, ctrlWrite = 1'b0;
  logic [7:0] rxByte = '0;
  logic [6:0] primAddr = '0, rangeAddr = '0, secAddr = '0;
  logic       gcEn = 1'b0, secEn = 1'b0, alertEn = 1'b0, rangeEn = 1'b0;
  logic       addressed, readDir, ackReq, xferDone;
  logic [2:0] matchKind;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  tgt_addr_match dut (
    .clk(clk), .rst_n(rst_n), .startSeen(startSeen), .byteValid(byteValid),
    .rxByte(rxByte), .primAddr(primAddr), .rangeAddr(rangeAddr), .secAddr(secAddr),
    .gcEn(gcEn), .secEn(secEn), .alertEn(alertEn), .rangeEn(rangeEn),
    .ctrlWrite(ctrlWrite), .addressed(addressed), .readDir(readDir),
    .matchKind(matchKind), .ackReq(ackReq), .xferDone(xferDone)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {1'b0, addressed, readDir, matchKind, ackReq, xferDone};
  endfunction

  // Expected winning code and how many sources hit, derived from R2-R8
  function automatic void model(input int a, input int rw, output int kind, output int nHits);
    bit h[1:6];
    h[1] = (a == primAddr);
    h[2] = (rangeAddr != 0) && (a == rangeAddr);
    h[3] = secEn && (a == secAddr);
    h[4] = gcEn && (a == 0) && (rw == 0);
    h[5] = alertEn && (a == 12);
    h[6] = rangeEn && (a >= primAddr) && (a <= rangeAddr);
    kind = 0;
    nHits = 0;
    for (int k = 6; k >= 1; k--) if (h[k]) begin kind = k; nHits++; end
  endfunction

  task automatic sendAddr(int a, int rw);
    @(negedge clk); startSeen = 1'b1; byteValid = 1'b0;
    @(negedge clk); startSeen = 1'b0; byteValid = 1'b1; rxByte = 8'((a << 1) | rw);
    check("R10 xferDone cleared by start", {7'b0, xferDone}, 8'h00);
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic sweep();
    int kind, nHits;
    string tag;
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        model(a, rw, kind, nHits);
        sendAddr(a, rw);
        if (nHits > 1) tag = "R8 priority";
        else case (kind)
          1: tag = "R2 primary";
          2: tag = "R3 range register";
          3: tag = "R4 second";
          4: tag = "R5 general call";
          5: tag = "R6 alert";
          6: tag = "R7 window";
          default: tag = "R9 no match";
        endcase
        check(tag, outs(),
              {1'b0, kind != 0, (kind != 0) && (rw == 1), 3'(kind), kind != 0, kind != 0});
        @(negedge clk);
        check("R10 ackReq single pulse", {7'b0, ackReq}, 8'h00);
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", outs(), 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset release", outs(), 8'h00);

    // Setup 0: primary only, zero range register
    primAddr = 7'h2A; rangeAddr = 7'h00; secAddr = 7'h55;
    gcEn = 0; secEn = 0; alertEn = 0; rangeEn = 0;
    sweep();
    // Setup 1: everything on, overlapping sources inside the window
    primAddr = 7'h10; rangeAddr = 7'h20; secAddr = 7'h18;
    gcEn = 1; secEn = 1; alertEn = 1; rangeEn = 1;
    sweep();
    // Setup 2: empty window, second address at zero, general call off
    primAddr = 7'h0C; rangeAddr = 7'h05; secAddr = 7'h00;
    gcEn = 0; secEn = 1; alertEn = 1; rangeEn = 1;
    sweep();
    // Setup 3: window reaching the top address
    primAddr = 7'h40; rangeAddr = 7'h7F; secAddr = 7'h01;
    gcEn = 1; secEn = 0; alertEn = 0; rangeEn = 1;
    sweep();

    // R11: only the first byte after a start counts
    primAddr = 7'h2A; rangeAddr = 7'h00; gcEn = 0; secEn = 0; alertEn = 0; rangeEn = 0;
    sendAddr(7'h2A, 1);
    check("R11 first byte matched", {7'b0, addressed}, 8'h01);
    @(negedge clk); byteValid = 1'b1; rxByte = 8'h00;
    @(negedge clk); byteValid = 1'b0;
    check("R11 second byte ignored", outs(), {1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1});

    // R12: a control write on its own clears addressed but keeps kind and direction
    @(negedge clk); ctrlWrite = 1'b1;
    @(negedge clk); ctrlWrite = 1'b0;
    check("R12 ctrlWrite clears addressed", outs(), {1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1});

    // R11: an unarmed byte is not evaluated
    @(negedge clk); byteValid = 1'b1; rxByte = {7'h2A, 1'b0};
    @(negedge clk); byteValid = 1'b0;
    check("R11 byte without start ignored", outs(), {1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1});

    // R11: a byte arriving in the same cycle as startSeen is ignored
    @(negedge clk); startSeen = 1'b1; byteValid = 1'b1; rxByte = {7'h2A, 1'b0};
    @(negedge clk); startSeen = 1'b0; byteValid = 1'b0;
    check("R11 byte with start ignored", {6'b0, addressed, ackReq}, 8'h00);

    // R12: a capture in the same cycle as ctrlWrite wins
    @(negedge clk); byteValid = 1'b1; ctrlWrite = 1'b1; rxByte = {7'h2A, 1'b0};
    @(negedge clk); byteValid = 1'b0; ctrlWrite = 1'b0;
    check("R12 capture beats ctrlWrite", outs(), {1'b0, 1'b1, 1'b0, 3'd1, 1'b1, 1'b1});

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule